// File: doc/BRIEF.md
# Memory-to-Memory DMA Engine

This block copies data between a main memory and an auxiliary memory, in either direction, in whole 32-byte bursts. Software sets it up through seven 16-bit registers. Two registers give the main-memory address and two give the auxiliary-memory address. A control register holds the direction bit and the high part of the byte length. A length-low register starts the transfer when it is written. While the engine runs, software can see a busy flag. When the last burst has landed, a sticky completion flag is set. That flag drives the interrupt output through a mask bit.

Each memory is reached through a simple request/acknowledge port that carries one 32-byte burst per handshake. For every burst the engine reads the source memory, keeps the data, writes it to the destination memory, and then advances both addresses by 32. The shared control/status register also keeps two sticky event flags for neighbouring audio and signal-processor sources, with their own mask bits, and a halt bit and a core-reset bit that are simply stored. Writing 1 to a dedicated bit of that register aborts a running transfer.

Top module: `ramxfer_dma`

## Requirements
- R1: After reset all seven registers read 0, `irq` is low and neither memory port requests.
- R2: Register indices are 0 control/status, 1 main address high, 2 main address low, 3 auxiliary address high, 4 auxiliary address low, 5 control, 6 length low. The high registers hold address bits [25:16] in bits [9:0]. The low registers hold bits [15:5] in bits [15:5]. Control holds the direction in bit 15 and length bits [25:16] in bits [9:0]. Every other bit, including bits [4:0] of the low registers, reads 0.
- R3: With control bit 15 = 0, data moves from main to auxiliary memory. With bit 15 = 1, data moves from auxiliary to main memory. Each burst is one read of the source port followed by one write of the destination port, and the two ports never request in the same cycle.
- R4: A transfer performs length/32 bursts. Both addresses advance by 32 after each burst. A request holds its address steady until it is acknowledged.
- R5: Control/status bit 9 (busy) reads 1 from the cycle after the start write until the clock edge that follows the last write acknowledge. The completion flag sets on that same edge.
- R6: `irq` equals control/status bit 5 (completion flag) AND bit 6 (its mask).
- R7: Writing 1 to control/status bit 5 clears the completion flag. Writing 0 there leaves it unchanged.
- R8: A start with zero length makes busy read 1 for exactly one cycle, sets the completion flag on the following edge, and makes no memory access.
- R9: A write to the length-low register while busy is ignored: the register keeps its value and no extra bursts run.
- R10: Writing 1 to control/status bit 11 aborts a running transfer. Busy reads 0 after that edge, no further requests follow, the completion flag is not set, and bit 11 reads 0.
- R11: Control/status bits 3 and 7 are sticky flags set by the `aud_evt` and `dsp_evt` inputs and cleared by writing 1. Bits 8, 6, 4, 2 and 0 are plain read/write bits.
- R12: A write to the length-low register while idle starts a transfer. The length is the current control bits [9:0] as bits [25:16] joined with the written bits [15:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_idx | input | 3 | Register index |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for `host_idx` |
| aud_evt | input | 1 | Sets audio event flag (bit 3) |
| dsp_evt | input | 1 | Sets signal-processor event flag (bit 7) |
| irq | output | 1 | Masked completion interrupt |
| mm_req | output | 1 | Main memory burst request |
| mm_we | output | 1 | Main memory request is a write |
| mm_addr | output | 26 | Main memory byte address (32-byte aligned) |
| mm_wdata | output | 256 | Main memory burst write data |
| mm_rdata | input | 256 | Main memory burst read data, valid with ack |
| mm_ack | input | 1 | Main memory acknowledge |
| ax_req | output | 1 | Auxiliary memory burst request |
| ax_we | output | 1 | Auxiliary memory request is a write |
| ax_addr | output | 26 | Auxiliary memory byte address (32-byte aligned) |
| ax_wdata | output | 256 | Auxiliary memory burst write data |
| ax_rdata | input | 256 | Auxiliary memory burst read data, valid with ack |
| ax_ack | input | 1 | Auxiliary memory acknowledge |

## Verification
The bench builds the engine with a 10-bit high address field and 32-byte bursts. That gives 26-bit addresses and a 21-bit burst counter. The memory models answer after a two-cycle wait, so every request is held across several cycles and the address-hold rule is exercised. Because the high length field is wide, a single non-zero bit in it starts a 2048-burst transfer even with a zero low length. That long-running transfer is what the abort test uses. Short transfers of two and three bursts in both directions, plus a zero-length start, cover the burst count, the address stepping and the completion timing.

// File: rtl/ramxfer_pkg.sv
// Shared constants for the memory-to-memory DMA engine.
// Assumes a 16-bit register interface; bit positions are fixed by software.
package ramxfer_pkg;

    // Register indices on the host side
    localparam logic [2:0] IDX_CSR     = 3'd0;
    localparam logic [2:0] IDX_MAIN_HI = 3'd1;
    localparam logic [2:0] IDX_MAIN_LO = 3'd2;
    localparam logic [2:0] IDX_AUX_HI  = 3'd3;
    localparam logic [2:0] IDX_AUX_LO  = 3'd4;
    localparam logic [2:0] IDX_CTRL    = 3'd5;
    localparam logic [2:0] IDX_LEN_LO  = 3'd6;

    // Control/status bit positions
    localparam int CSR_ABORT   = 11;
    localparam int CSR_BUSY    = 9;
    localparam int CSR_DSP_MSK = 8;
    localparam int CSR_DSP_FLG = 7;
    localparam int CSR_DMA_MSK = 6;
    localparam int CSR_DMA_FLG = 5;
    localparam int CSR_AUD_MSK = 4;
    localparam int CSR_AUD_FLG = 3;
    localparam int CSR_HALT    = 2;
    localparam int CSR_CORE_RS = 0;

    // Control register direction bit
    localparam int CTRL_DIR = 15;

    // Burst sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_DONE  = 2'd3
    } sq_state_e;

endpackage

// File: rtl/ramxfer_regs.sv
// Register file for the DMA engine.
// Holds the address, length and direction registers and the shared
// control/status register with its write-one-to-clear flags. Decodes the
// start write (length-low while idle) and the abort write (bit 11).
// Assumes one host write per cycle; reads are combinational.
module ramxfer_regs
    import ramxfer_pkg::*;
#(
    parameter int HI_W  = 10,
    parameter int OFS_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic [2:0]                 host_idx,
    input  logic [15:0]                host_wdata,
    output logic [15:0]                host_rdata,
    input  logic                       aud_evt,
    input  logic                       dsp_evt,
    input  logic                       busy,
    input  logic                       done,
    output logic [HI_W+16-1:0]         main_addr,
    output logic [HI_W+16-1:0]         aux_addr,
    output logic                       to_main,
    output logic [HI_W+16-OFS_W-1:0]   bursts,
    output logic                       start,
    output logic                       abort,
    output logic                       dma_flag,
    output logic                       dma_mask
);
    localparam int LO_W = 16 - OFS_W;

    logic [HI_W-1:0] main_hi, aux_hi, len_hi;
    logic [LO_W-1:0] main_lo, aux_lo, len_lo;
    logic            dir_bit;
    logic            dsp_msk, dsp_flg, aud_msk, aud_flg, halt_bit, core_rs;
    logic            wr_csr, wr_len;

    // Decode the two register writes that have side effects
    always_comb begin
        wr_csr = host_wr && (host_idx == IDX_CSR);
        wr_len = host_wr && (host_idx == IDX_LEN_LO);
        start  = wr_len && !busy;
        abort  = wr_csr && host_wdata[CSR_ABORT];
    end

    // Present addresses and the burst count to the sequencer
    always_comb begin
        main_addr = {main_hi, main_lo, {OFS_W{1'b0}}};
        aux_addr  = {aux_hi, aux_lo, {OFS_W{1'b0}}};
        to_main   = dir_bit;
        bursts    = {len_hi, host_wdata[15:OFS_W]};
    end

    // Address, length and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_hi <= '0;
            main_lo <= '0;
            aux_hi  <= '0;
            aux_lo  <= '0;
            len_hi  <= '0;
            len_lo  <= '0;
            dir_bit <= 1'b0;
        end else if (host_wr) begin
            case (host_idx)
                IDX_MAIN_HI: main_hi <= host_wdata[HI_W-1:0];
                IDX_MAIN_LO: main_lo <= host_wdata[15:OFS_W];
                IDX_AUX_HI:  aux_hi  <= host_wdata[HI_W-1:0];
                IDX_AUX_LO:  aux_lo  <= host_wdata[15:OFS_W];
                IDX_CTRL: begin
                    dir_bit <= host_wdata[CTRL_DIR];
                    len_hi  <= host_wdata[HI_W-1:0];
                end
                IDX_LEN_LO: if (!busy) len_lo <= host_wdata[15:OFS_W];
                default: ;
            endcase
        end
    end

    // Plain read/write control bits of the status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_msk  <= 1'b0;
            dma_mask <= 1'b0;
            aud_msk  <= 1'b0;
            halt_bit <= 1'b0;
            core_rs  <= 1'b0;
        end else if (wr_csr) begin
            dsp_msk  <= host_wdata[CSR_DSP_MSK];
            dma_mask <= host_wdata[CSR_DMA_MSK];
            aud_msk  <= host_wdata[CSR_AUD_MSK];
            halt_bit <= host_wdata[CSR_HALT];
            core_rs  <= host_wdata[CSR_CORE_RS];
        end
    end

    // Sticky flags: set by their source, cleared by writing one; set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_flag <= 1'b0;
            aud_flg  <= 1'b0;
            dsp_flg  <= 1'b0;
        end else begin
            dma_flag <= done    | (dma_flag & ~(wr_csr & host_wdata[CSR_DMA_FLG]));
            aud_flg  <= aud_evt | (aud_flg  & ~(wr_csr & host_wdata[CSR_AUD_FLG]));
            dsp_flg  <= dsp_evt | (dsp_flg  & ~(wr_csr & host_wdata[CSR_DSP_FLG]));
        end
    end

    // Read-back multiplexer
    always_comb begin
        host_rdata = '0;
        case (host_idx)
            IDX_CSR: begin
                host_rdata[CSR_BUSY]    = busy;
                host_rdata[CSR_DSP_MSK] = dsp_msk;
                host_rdata[CSR_DSP_FLG] = dsp_flg;
                host_rdata[CSR_DMA_MSK] = dma_mask;
                host_rdata[CSR_DMA_FLG] = dma_flag;
                host_rdata[CSR_AUD_MSK] = aud_msk;
                host_rdata[CSR_AUD_FLG] = aud_flg;
                host_rdata[CSR_HALT]    = halt_bit;
                host_rdata[CSR_CORE_RS] = core_rs;
            end
            IDX_MAIN_HI: host_rdata[HI_W-1:0]  = main_hi;
            IDX_MAIN_LO: host_rdata[15:OFS_W]  = main_lo;
            IDX_AUX_HI:  host_rdata[HI_W-1:0]  = aux_hi;
            IDX_AUX_LO:  host_rdata[15:OFS_W]  = aux_lo;
            IDX_CTRL: begin
                host_rdata[CTRL_DIR]   = dir_bit;
                host_rdata[HI_W-1:0]   = len_hi;
            end
            IDX_LEN_LO:  host_rdata[15:OFS_W]  = len_lo;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ramxfer_seq.sv
// Burst sequencer for the DMA engine.
// Runs one read of the source and one write of the destination per burst,
// stepping both addresses by one burst, until the count is exhausted.
// Assumes a memory holds its acknowledge for one cycle with read data valid.
module ramxfer_seq
    import ramxfer_pkg::*;
#(
    parameter int ADDR_W      = 26,
    parameter int CNT_W       = 21,
    parameter int DATA_W      = 256,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              to_main,
    input  logic [ADDR_W-1:0] main_addr,
    input  logic [ADDR_W-1:0] aux_addr,
    input  logic [CNT_W-1:0]  bursts,
    input  logic              src_ack,
    input  logic [DATA_W-1:0] src_rdata,
    input  logic              dst_ack,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    output logic              dst_req,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [DATA_W-1:0] dst_wdata,
    output logic              dir_q,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    sq_state_e         st;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] buf_q;

    // Burst state machine with latched transfer parameters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
            buf_q  <= '0;
            dir_q  <= 1'b0;
        end else if (abort) begin
            st <= SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    dir_q  <= to_main;
                    src_q  <= to_main ? aux_addr : main_addr;
                    dst_q  <= to_main ? main_addr : aux_addr;
                    left_q <= bursts;
                    st     <= (bursts == '0) ? SQ_DONE : SQ_READ;
                end
                SQ_READ: if (src_ack) begin
                    buf_q <= src_rdata;
                    st    <= SQ_WRITE;
                end
                SQ_WRITE: if (dst_ack) begin
                    src_q  <= src_q + STEP;
                    dst_q  <= dst_q + STEP;
                    left_q <= left_q - ONE;
                    st     <= (left_q == ONE) ? SQ_DONE : SQ_READ;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Drive the generic source/destination request lines
    always_comb begin
        src_req   = (st == SQ_READ);
        dst_req   = (st == SQ_WRITE);
        src_addr  = src_q;
        dst_addr  = dst_q;
        dst_wdata = buf_q;
        busy      = (st != SQ_IDLE);
        done      = (st == SQ_DONE) && !abort;
    end

endmodule

// File: rtl/ramxfer_route.sv
// Port router for the DMA engine.
// Maps the sequencer's source and destination onto the main and auxiliary
// memory ports according to the latched direction. Purely combinational.
module ramxfer_route #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 256
) (
    input  logic              dir_q,
    input  logic              src_req,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic              dst_req,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] dst_wdata,
    output logic              src_ack,
    output logic [DATA_W-1:0] src_rdata,
    output logic              dst_ack,
    output logic              mm_req,
    output logic              mm_we,
    output logic [ADDR_W-1:0] mm_addr,
    output logic [DATA_W-1:0] mm_wdata,
    input  logic [DATA_W-1:0] mm_rdata,
    input  logic              mm_ack,
    output logic              ax_req,
    output logic              ax_we,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [DATA_W-1:0] ax_wdata,
    input  logic [DATA_W-1:0] ax_rdata,
    input  logic              ax_ack
);
    // Steer requests and responses; dir_q = 1 means auxiliary to main
    always_comb begin
        mm_req    = dir_q ? dst_req  : src_req;
        mm_we     = dir_q & dst_req;
        mm_addr   = dir_q ? dst_addr : src_addr;
        mm_wdata  = dst_wdata;
        ax_req    = dir_q ? src_req  : dst_req;
        ax_we     = ~dir_q & dst_req;
        ax_addr   = dir_q ? src_addr : dst_addr;
        ax_wdata  = dst_wdata;
        src_ack   = dir_q ? ax_ack   : mm_ack;
        src_rdata = dir_q ? ax_rdata : mm_rdata;
        dst_ack   = dir_q ? mm_ack   : ax_ack;
    end

endmodule

// File: rtl/ramxfer_dma.sv
// Top of the register-programmed memory-to-memory DMA engine.
// Connects the register file, the burst sequencer and the port router.
// Assumes both memories use 32-byte aligned single-burst handshakes.
module ramxfer_dma #(
    parameter int ADDR_HI_W   = 10,
    parameter int BURST_BYTES = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_wr,
    input  logic [2:0]                   host_idx,
    input  logic [15:0]                  host_wdata,
    output logic [15:0]                  host_rdata,
    input  logic                         aud_evt,
    input  logic                         dsp_evt,
    output logic                         irq,
    output logic                         mm_req,
    output logic                         mm_we,
    output logic [ADDR_HI_W+16-1:0]      mm_addr,
    output logic [BURST_BYTES*8-1:0]     mm_wdata,
    input  logic [BURST_BYTES*8-1:0]     mm_rdata,
    input  logic                         mm_ack,
    output logic                         ax_req,
    output logic                         ax_we,
    output logic [ADDR_HI_W+16-1:0]      ax_addr,
    output logic [BURST_BYTES*8-1:0]     ax_wdata,
    input  logic [BURST_BYTES*8-1:0]     ax_rdata,
    input  logic                         ax_ack
);
    localparam int OFS_W  = $clog2(BURST_BYTES);
    localparam int ADDR_W = ADDR_HI_W + 16;
    localparam int CNT_W  = ADDR_W - OFS_W;
    localparam int DATA_W = BURST_BYTES * 8;

    logic              busy, done, start, abort, to_main, dir_q;
    logic              dma_flag, dma_mask;
    logic [ADDR_W-1:0] main_addr, aux_addr, src_addr, dst_addr;
    logic [CNT_W-1:0]  bursts;
    logic              src_req, dst_req, src_ack, dst_ack;
    logic [DATA_W-1:0] src_rdata, dst_wdata;
    logic              zero_len;

    ramxfer_regs #(.HI_W(ADDR_HI_W), .OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .aud_evt(aud_evt), .dsp_evt(dsp_evt),
        .busy(busy), .done(done),
        .main_addr(main_addr), .aux_addr(aux_addr), .to_main(to_main),
        .bursts(bursts), .start(start), .abort(abort),
        .dma_flag(dma_flag), .dma_mask(dma_mask)
    );

    ramxfer_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .BURST_BYTES(BURST_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .to_main(to_main), .main_addr(main_addr), .aux_addr(aux_addr),
        .bursts(bursts), .src_ack(src_ack), .src_rdata(src_rdata),
        .dst_ack(dst_ack), .src_req(src_req), .src_addr(src_addr),
        .dst_req(dst_req), .dst_addr(dst_addr), .dst_wdata(dst_wdata),
        .dir_q(dir_q), .busy(busy), .done(done)
    );

    ramxfer_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
        .dir_q(dir_q), .src_req(src_req), .src_addr(src_addr),
        .dst_req(dst_req), .dst_addr(dst_addr), .dst_wdata(dst_wdata),
        .src_ack(src_ack), .src_rdata(src_rdata), .dst_ack(dst_ack),
        .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_ack(mm_ack),
        .ax_req(ax_req), .ax_we(ax_we), .ax_addr(ax_addr),
        .ax_wdata(ax_wdata), .ax_rdata(ax_rdata), .ax_ack(ax_ack)
    );

    // Masked completion interrupt and zero-length start indication
    always_comb begin
        irq      = dma_flag & dma_mask;
        zero_len = (bursts == '0);
    end

endmodule

// File: rtl/ramxfer_chk.sv
// Assertion checker for the DMA engine, bound to the top module.
// Relates the sequencer's busy state, the register file's decodes and the
// memory port handshakes over time.
module ramxfer_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              start,
    input logic              abort,
    input logic              zero_len,
    input logic              dma_flag,
    input logic              host_wr,
    input logic [2:0]        host_idx,
    input logic [15:0]       host_wdata,
    input logic              mm_req,
    input logic              mm_ack,
    input logic [ADDR_W-1:0] mm_addr,
    input logic              ax_req,
    input logic              ax_ack,
    input logic [ADDR_W-1:0] ax_addr
);
    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mm_req || ax_req));

    // R3: one port at a time
    a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mm_req, ax_req}));

    // R4: main request held with stable address until acknowledged
    a_r4_mm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && !mm_ack && !abort) |=> (mm_req && $stable(mm_addr)));

    // R4: auxiliary request held with stable address until acknowledged
    a_r4_ax_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_req && !ax_ack && !abort) |=> (ax_req && $stable(ax_addr)));

    // R5: busy falling without an abort always comes with the completion flag
    a_r5_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort)) |-> dma_flag);

    // R7: the completion flag only clears through a write of one to bit 5
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_flag && !(host_wr && host_idx == 3'd0 && host_wdata[5])) |=> dma_flag);

    // R8: zero-length start is busy for a cycle with no memory access
    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && zero_len && !abort) |=> (busy && !mm_req && !ax_req));

    // R9: no start is decoded while the engine is busy
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    // R10: an abort leaves the engine idle on the next cycle
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

endmodule

bind ramxfer_dma ramxfer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .abort(abort),
    .zero_len(zero_len), .dma_flag(dma_flag), .host_wr(host_wr),
    .host_idx(host_idx), .host_wdata(host_wdata),
    .mm_req(mm_req), .mm_ack(mm_ack), .mm_addr(mm_addr),
    .ax_req(ax_req), .ax_ack(ax_ack), .ax_addr(ax_addr)
);

// File: tb/tb_ramxfer_dma.sv
`timescale 1ns/1ps
// Scoreboard bench for the DMA engine: a driver task queues the expected
// destination writes, a monitor pops and compares them as they happen.
module tb_ramxfer_dma;
    localparam int HI_W   = 10;
    localparam int BB     = 32;
    localparam int AW     = HI_W + 16;
    localparam int DW     = BB * 8;
    localparam int LAT    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [2:0]    host_idx = 3'd0;
    logic [15:0]   host_wdata = 16'h0;
    logic [15:0]   host_rdata;
    logic          aud_evt = 1'b0, dsp_evt = 1'b0;
    logic          irq;
    logic          mm_req, mm_we, mm_ack, ax_req, ax_we, ax_ack;
    logic [AW-1:0] mm_addr, ax_addr;
    logic [DW-1:0] mm_wdata, mm_rdata, ax_wdata, ax_rdata;

    int checks = 0, fails = 0;
    int m_rd = 0, m_wr = 0, a_rd = 0, a_wr = 0;
    int mcnt = 0, acnt = 0;
    bit sb_on = 1'b1;

    logic [DW-1:0] mmem [64];
    logic [DW-1:0] amem [64];

    typedef struct {
        bit            to_main;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } exp_t;
    exp_t sbq [$];

    always #2 clk = ~clk;

    ramxfer_dma #(.ADDR_HI_W(HI_W), .BURST_BYTES(BB)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .aud_evt(aud_evt), .dsp_evt(dsp_evt), .irq(irq),
        .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_rdata(mm_rdata), .mm_ack(mm_ack),
        .ax_req(ax_req), .ax_we(ax_we), .ax_addr(ax_addr), .ax_wdata(ax_wdata),
        .ax_rdata(ax_rdata), .ax_ack(ax_ack)
    );

    function automatic logic [DW-1:0] pat(bit aux, int idx);
        logic [DW-1:0] r;
        for (int k = 0; k < DW/32; k++)
            r[32*k +: 32] = (aux ? 32'hA500_0000 : 32'h3C00_0000) ^ (idx << 8) ^ k;
        return r;
    endfunction

    // Main memory model: fixed wait, one-cycle ack
    always @(posedge clk) begin
        if (!rst_n) begin
            mm_ack <= 1'b0; mcnt <= 0; mm_rdata <= '0;
        end else begin
            mm_ack <= 1'b0;
            if (mm_req && !mm_ack) begin
                if (mcnt == LAT) begin
                    mm_ack <= 1'b1; mcnt <= 0;
                    if (mm_we) begin mmem[mm_addr[10:5]] <= mm_wdata; m_wr <= m_wr + 1; end
                    else begin mm_rdata <= mmem[mm_addr[10:5]]; m_rd <= m_rd + 1; end
                end else mcnt <= mcnt + 1;
            end else if (!mm_req) mcnt <= 0;
        end
    end

    // Auxiliary memory model
    always @(posedge clk) begin
        if (!rst_n) begin
            ax_ack <= 1'b0; acnt <= 0; ax_rdata <= '0;
        end else begin
            ax_ack <= 1'b0;
            if (ax_req && !ax_ack) begin
                if (acnt == LAT) begin
                    ax_ack <= 1'b1; acnt <= 0;
                    if (ax_we) begin amem[ax_addr[10:5]] <= ax_wdata; a_wr <= a_wr + 1; end
                    else begin ax_rdata <= amem[ax_addr[10:5]]; a_rd <= a_rd + 1; end
                end else acnt <= acnt + 1;
            end else if (!ax_req) acnt <= 0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sb_pop(bit to_main, logic [AW-1:0] a, logic [DW-1:0] d);
        exp_t e;
        checks++;
        if (sbq.size() == 0) begin
            fails++;
            $display("FAIL R4 unexpected write actual=0x%0h expected=none", a);
        end else begin
            e = sbq.pop_front();
            if (e.to_main != to_main || e.a !== a || e.d !== d) begin
                fails++;
                $display("FAIL R3/R4 write actual=%0d:0x%0h:0x%0h expected=%0d:0x%0h:0x%0h",
                         to_main, a, d[31:0], e.to_main, e.a, e.d[31:0]);
            end
        end
    endtask

    // Monitor: compare each destination write with the queue head
    always @(negedge clk) begin
        if (rst_n && sb_on) begin
            if (mm_req && mm_we && mm_ack) sb_pop(1'b1, mm_addr, mm_wdata);
            if (ax_req && ax_we && ax_ack) sb_pop(1'b0, ax_addr, ax_wdata);
        end
    end

    // Driver: queue the writes a transfer must produce
    task automatic push_xfer(bit to_main, logic [AW-1:0] dst, int src_idx, int n);
        exp_t e;
        for (int i = 0; i < n; i++) begin
            e.to_main = to_main;
            e.a = dst + AW'(32 * i);
            e.d = pat(to_main, src_idx + i);
            sbq.push_back(e);
        end
    endtask

    task automatic wr(logic [2:0] idx, logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_idx = idx; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic peek(logic [2:0] idx, output logic [15:0] v);
        host_idx = idx;
        #0.5;
        v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            peek(3'd0, v);
            if (!v[9]) break;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int s0, s1, s2, s3;
        for (int i = 0; i < 64; i++) begin mmem[i] = pat(1'b0, i); amem[i] = pat(1'b1, i); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 7; i++) begin
            peek(3'(i), v);
            chk("R1 reset register", {16'h0, v}, 32'h0);
        end
        chk("R1 reset irq/requests", {29'h0, irq, mm_req, ax_req}, 32'h0);

        // R2: register field layout
        wr(3'd1, 16'hFFFF); peek(3'd1, v); chk("R2 main high", {16'h0, v}, 32'h03FF);
        wr(3'd2, 16'hFFFF); peek(3'd2, v); chk("R2 main low", {16'h0, v}, 32'hFFE0);
        wr(3'd3, 16'hFFFF); peek(3'd3, v); chk("R2 aux high", {16'h0, v}, 32'h03FF);
        wr(3'd4, 16'hFFFF); peek(3'd4, v); chk("R2 aux low", {16'h0, v}, 32'hFFE0);
        wr(3'd5, 16'hFFFF); peek(3'd5, v); chk("R2 control", {16'h0, v}, 32'h83FF);

        // R3 R4 R5 R6 R12: main to aux, three bursts, mask on
        wr(3'd0, 16'h0040);
        wr(3'd1, 16'h0000); wr(3'd2, 16'h0040);
        wr(3'd3, 16'h0001); wr(3'd4, 16'h0400);
        wr(3'd5, 16'h0000);
        push_xfer(1'b0, 26'h010400, 2, 3);
        s0 = m_rd; s1 = m_wr; s2 = a_rd; s3 = a_wr;
        wr(3'd6, 16'h0060);
        peek(3'd0, v); chk("R5 busy after start", {31'h0, v[9]}, 32'h1);
        wait_idle();
        peek(3'd0, v); chk("R5 flag at end", {31'h0, v[5]}, 32'h1);
        chk("R6 irq with mask", {31'h0, irq}, 32'h1);
        chk("R4 queue drained", sbq.size(), 32'h0);
        chk("R3 source reads main", m_rd - s0, 32'd3);
        chk("R3 dest writes aux", a_wr - s3, 32'd3);
        chk("R3 no reverse traffic", (m_wr - s1) + (a_rd - s2), 32'd0);
        peek(3'd6, v); chk("R12 length low kept", {16'h0, v}, 32'h0060);

        // R3 R6 R7: aux to main, two bursts, mask off
        wr(3'd0, 16'h0020);
        peek(3'd0, v); chk("R7 write one clears flag", {31'h0, v[5]}, 32'h0);
        wr(3'd1, 16'h0002); wr(3'd2, 16'h0500);
        wr(3'd3, 16'h0000); wr(3'd4, 16'h0140);
        wr(3'd5, 16'h8000);
        push_xfer(1'b1, 26'h020500, 10, 2);
        wr(3'd6, 16'h0040);
        wait_idle();
        peek(3'd0, v); chk("R5 flag aux to main", {31'h0, v[5]}, 32'h1);
        chk("R6 irq masked off", {31'h0, irq}, 32'h0);
        chk("R4 queue drained aux to main", sbq.size(), 32'h0);
        wr(3'd0, 16'h0040);
        peek(3'd0, v); chk("R7 write zero keeps flag", {31'h0, v[5]}, 32'h1);
        chk("R6 irq follows mask", {31'h0, irq}, 32'h1);
        wr(3'd0, 16'h0060);
        chk("R6 irq after clear", {31'h0, irq}, 32'h0);

        // R8: zero-length start
        wr(3'd5, 16'h0000);
        s0 = m_rd + m_wr + a_rd + a_wr;
        wr(3'd6, 16'h0000);
        peek(3'd0, v); chk("R8 zero length busy one cycle", {30'h0, v[9], v[5]}, 32'h2);
        @(negedge clk);
        peek(3'd0, v); chk("R8 zero length flag next edge", {30'h0, v[9], v[5]}, 32'h1);
        repeat (4) @(negedge clk);
        chk("R8 no memory access", (m_rd + m_wr + a_rd + a_wr) - s0, 32'd0);
        wr(3'd0, 16'h0060);

        // R9: start while busy ignored
        wr(3'd1, 16'h0000); wr(3'd2, 16'h0280);
        wr(3'd3, 16'h0000); wr(3'd4, 16'h0640);
        push_xfer(1'b0, 26'h000640, 20, 3);
        s3 = a_wr;
        wr(3'd6, 16'h0060);
        wr(3'd6, 16'h00A0);
        peek(3'd6, v); chk("R9 length low unchanged", {16'h0, v}, 32'h0060);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R9 only three bursts", a_wr - s3, 32'd3);
        chk("R9 queue drained", sbq.size(), 32'h0);
        wr(3'd0, 16'h0060);

        // R12 R10: high length part, then abort
        sb_on = 1'b0;
        wr(3'd5, 16'h0001);
        wr(3'd6, 16'h0000);
        repeat (20) @(negedge clk);
        peek(3'd0, v); chk("R12 high length part starts", {31'h0, v[9]}, 32'h1);
        wr(3'd0, 16'h0840);
        peek(3'd0, v); chk("R10 busy cleared by abort", {31'h0, v[9]}, 32'h0);
        chk("R10 abort bit reads zero", {31'h0, v[11]}, 32'h0);
        @(negedge clk);
        s0 = m_rd + m_wr + a_rd + a_wr;
        repeat (20) @(negedge clk);
        chk("R10 no access after abort", (m_rd + m_wr + a_rd + a_wr) - s0, 32'd0);
        peek(3'd0, v); chk("R10 no completion flag", {31'h0, v[5]}, 32'h0);
        sb_on = 1'b1;

        // R11: side flags and plain bits
        @(negedge clk); aud_evt = 1'b1; @(negedge clk); aud_evt = 1'b0;
        @(negedge clk); dsp_evt = 1'b1; @(negedge clk); dsp_evt = 1'b0;
        peek(3'd0, v); chk("R11 event flags set", {16'h0, v & 16'h0088}, 32'h0088);
        wr(3'd0, 16'h0008);
        peek(3'd0, v); chk("R11 audio flag cleared, dsp kept", {16'h0, v & 16'h0088}, 32'h0080);
        wr(3'd0, 16'h0155);
        peek(3'd0, v); chk("R11 plain bits", {16'h0, v}, 32'h01D5);
        wr(3'd0, 16'h0080);
        peek(3'd0, v); chk("R11 dsp flag cleared", {31'h0, v[7]}, 32'h0);

        summary();
        $finish;
    end

endmodule